// File: doc/BRIEF.md
# Serial Audio Sine Tone Generator

This block produces a never-ending stereo test tone, a 1 kHz sine sampled at 44.1 kHz, as a left-justified serial audio stream that an external S/PDIF transmitter can take directly. Its only inputs are a master clock of 11.2896 MHz (256 times the sample rate) and an active-low reset. After reset it starts streaming at once and never stops.

A single binary divider clocked by the master clock provides every timing signal. Its low bits give the bit clock (master clock divided by 8), its middle bits count the bit position inside a 16-bit channel slot, and its top bit is the word-select clock. A separate sample index walks a table of 441 16-bit two's-complement samples. That is exactly ten periods of the tone, so the loop repeats without a phase jump. The index returns to zero when it meets an end marker stored beside the last sample. It does not wrap at a power of two. The table is computed during elaboration at about half of full scale. The same sample is sent in both channel slots of a frame. The master clock is also passed through unchanged for use by the transmitter.

Top module: `toneSerialGen`

## Requirements
- R1: `mclkOut` follows `clkMaster` unchanged: high while the master clock is high and low while it is low.
- R2: `bitClk` is the master clock divided by 8. Each level lasts 4 master cycles, and after reset the first level is low for 4 cycles.
- R3: `wordSel` changes only together with a falling `bitClk` edge and toggles every 16 bit clocks (128 master cycles). It is low for the first slot of each 256-cycle frame (left channel) and high for the second (right channel).
- R4: `serData` changes only on master edges where `bitClk` falls. It is therefore steady throughout each bit clock high phase.
- R5: Each slot carries one 16-bit two's-complement word, MSB first, with no delay. The MSB occupies the first bit period after the `wordSel` edge and the LSB the sixteenth.
- R6: Within a frame, the right-channel slot carries the same word as the left-channel slot.
- R7: Frame f (counted from zero after reset) carries table entry n = f mod 441. Entry n equals round(16383 × sin(2π·10·n/441)), and the index advances by exactly one at each frame boundary.
- R8: After entry 440, whose stored end marker is set, the next frame carries entry 0. The stream therefore repeats every 441 frames without a phase jump.
- R9: While `rstN` is low, `bitClk`, `wordSel` and `serData` are low and the index is 0. Reset acts without waiting for a clock edge. After release, the first frame carries entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkMaster | input | 1 | Master clock, 256 × sample rate |
| rstN | input | 1 | Asynchronous active-low reset |
| mclkOut | output | 1 | Master clock pass-through for the transmitter |
| bitClk | output | 1 | Serial bit clock, master clock / 8 |
| wordSel | output | 1 | Channel select: low = left slot, high = right slot |
| serData | output | 1 | Left-justified serial sample data, MSB first |

## Verification
The bench runs past the 441st frame, so a design that wrapped at 512 entries, or that ignored the end marker, would send a wrong word or a jump in phase right after entry 440. Each slot is rebuilt from the bits sampled at the bit clock's rising edge and compared with a sine computed in the bench. This catches a one-bit shift of the left-justified alignment, an LSB-first order, and a right slot that lags the left slot by one entry. Resets asserted at random points, including mid-word, check that the stream stops at once and restarts from entry 0 with a clean first bit clock level.

// File: rtl/toneGenPkg.sv
package toneGenPkg;

  localparam int DefMclkLog2   = 3;
  localparam int DefSampleW    = 16;
  localparam int DefTableLen   = 441;
  localparam int DefToneCycles = 10;
  localparam int DefAmplitude  = 16383;

  localparam real TwoPi = 6.283185307179586;

  typedef struct packed {
    logic bitStart;    // next master edge begins a new bit period
    logic frameStart;  // next master edge begins a new stereo frame
  } toneStrobes_t;

  // Sine by power series; argument kept within [-pi, pi] by the caller.
  function automatic real sinSeries(real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int i = 1; i < 12; i++) begin
      term = -term * x * x / real'((2 * i) * (2 * i + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Table entry n: amp * sin(2*pi*cycles*n/len), rounded half away from zero.
  function automatic int toneSample(int n, int cycles, int len, int amp);
    int  phaseK;
    real v;
    phaseK = (n * cycles) % len;
    if (2 * phaseK > len) phaseK = phaseK - len;
    v = real'(amp) * sinSeries(TwoPi * real'(phaseK) / real'(len));
    if (v >= 0.0) return $rtoi(v + 0.5);
    return $rtoi(v - 0.5);
  endfunction

endpackage

// File: rtl/toneDivider.sv
module toneDivider
  import toneGenPkg::*;
#(
  parameter int MCLK_LOG2 = DefMclkLog2,
  parameter int POS_W     = 4
) (
  input  logic             clkMaster,
  input  logic             rstN,
  output logic             bitClk,
  output logic             wordSel,
  output logic [POS_W-1:0] nextBitPos,
  output toneStrobes_t     strobes
);

  localparam int CntW = MCLK_LOG2 + POS_W + 1;

  logic [CntW-1:0] divCnt;

  always_ff @(posedge clkMaster or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  // Low half of each bit period first, so data moves on the falling edge.
  assign bitClk     = divCnt[MCLK_LOG2-1];
  assign wordSel    = divCnt[CntW-1];
  assign nextBitPos = divCnt[MCLK_LOG2 +: POS_W] + 1'b1;

  assign strobes.bitStart   = &divCnt[MCLK_LOG2-1:0];
  assign strobes.frameStart = &divCnt;

endmodule

// File: rtl/toneTableRom.sv
module toneTableRom
  import toneGenPkg::*;
#(
  parameter int SAMPLE_W    = DefSampleW,
  parameter int TABLE_LEN   = DefTableLen,
  parameter int TONE_CYCLES = DefToneCycles,
  parameter int AMPLITUDE   = DefAmplitude,
  parameter int IDX_W       = 9
) (
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [SAMPLE_W-1:0] rdSample,
  output logic                rdLast
);

  localparam int Depth = 1 << IDX_W;

  logic [SAMPLE_W:0] romWord [Depth];

  for (genvar gi = 0; gi < Depth; gi++) begin : g_entry
    if (gi < TABLE_LEN) begin : g_used
      localparam int SampleVal = toneSample(gi, TONE_CYCLES, TABLE_LEN, AMPLITUDE);
      localparam bit IsLast    = (gi == TABLE_LEN - 1);
      assign romWord[gi] = {IsLast, SAMPLE_W'(SampleVal)};
    end else begin : g_pad
      assign romWord[gi] = '0;
    end
  end

  assign {rdLast, rdSample} = romWord[rdIdx];

endmodule

// File: rtl/toneSampleShifter.sv
module toneSampleShifter
  import toneGenPkg::*;
#(
  parameter int SAMPLE_W    = DefSampleW,
  parameter int POS_W       = 4,
  parameter int TABLE_LEN   = DefTableLen,
  parameter int TONE_CYCLES = DefToneCycles,
  parameter int AMPLITUDE   = DefAmplitude,
  parameter int IDX_W       = 9
) (
  input  logic             clkMaster,
  input  logic             rstN,
  input  toneStrobes_t     strobes,
  input  logic [POS_W-1:0] nextBitPos,
  output logic             serData,
  output logic [IDX_W-1:0] sampleIdx
);

  localparam bit ResetLast = (TABLE_LEN == 1);

  logic                curLast;
  logic [IDX_W-1:0]    idxNext;
  logic [SAMPLE_W-1:0] sampleNext;
  logic                lastNext;

  // Index steps at frame start; the stored marker returns it to zero.
  always_comb begin
    idxNext = sampleIdx;
    if (strobes.frameStart) idxNext = curLast ? '0 : sampleIdx + 1'b1;
  end

  toneTableRom #(
    .SAMPLE_W   (SAMPLE_W),
    .TABLE_LEN  (TABLE_LEN),
    .TONE_CYCLES(TONE_CYCLES),
    .AMPLITUDE  (AMPLITUDE),
    .IDX_W      (IDX_W)
  ) uRom (
    .rdIdx   (idxNext),
    .rdSample(sampleNext),
    .rdLast  (lastNext)
  );

  always_ff @(posedge clkMaster or negedge rstN) begin
    if (!rstN) begin
      sampleIdx <= '0;
      curLast   <= ResetLast;
      serData   <= 1'b0;
    end else begin
      if (strobes.frameStart) begin
        sampleIdx <= idxNext;
        curLast   <= lastNext;
      end
      // Bit position p maps to sample bit (SAMPLE_W-1-p): MSB first.
      if (strobes.bitStart) serData <= sampleNext[~nextBitPos];
    end
  end

endmodule

// File: rtl/toneSerialGen.sv
module toneSerialGen
  import toneGenPkg::*;
#(
  parameter int MCLK_LOG2   = DefMclkLog2,
  parameter int SAMPLE_W    = DefSampleW,
  parameter int TABLE_LEN   = DefTableLen,
  parameter int TONE_CYCLES = DefToneCycles,
  parameter int AMPLITUDE   = DefAmplitude
) (
  input  logic clkMaster,
  input  logic rstN,
  output logic mclkOut,
  output logic bitClk,
  output logic wordSel,
  output logic serData
);

  localparam int PosW = $clog2(SAMPLE_W);
  localparam int IdxW = $clog2(TABLE_LEN);

  toneStrobes_t    strobes;
  logic [PosW-1:0] nextBitPos;
  logic [IdxW-1:0] sampleIdx;

  assign mclkOut = clkMaster;

  toneDivider #(
    .MCLK_LOG2(MCLK_LOG2),
    .POS_W    (PosW)
  ) uDiv (
    .clkMaster (clkMaster),
    .rstN      (rstN),
    .bitClk    (bitClk),
    .wordSel   (wordSel),
    .nextBitPos(nextBitPos),
    .strobes   (strobes)
  );

  toneSampleShifter #(
    .SAMPLE_W   (SAMPLE_W),
    .POS_W      (PosW),
    .TABLE_LEN  (TABLE_LEN),
    .TONE_CYCLES(TONE_CYCLES),
    .AMPLITUDE  (AMPLITUDE),
    .IDX_W      (IdxW)
  ) uData (
    .clkMaster (clkMaster),
    .rstN      (rstN),
    .strobes   (strobes),
    .nextBitPos(nextBitPos),
    .serData   (serData),
    .sampleIdx (sampleIdx)
  );

endmodule

// File: rtl/toneSerialGenChk.sv
module toneSerialGenChk #(
  parameter int IDX_W     = 9,
  parameter int TABLE_LEN = 441
) (
  input logic             clkMaster,
  input logic             rstN,
  input logic             bitClk,
  input logic             wordSel,
  input logic             serData,
  input logic [IDX_W-1:0] sampleIdx
);

  logic [2:0] cycSinceRst;

  always_ff @(posedge clkMaster or negedge rstN) begin
    if (!rstN)                   cycSinceRst <= '0;
    else if (cycSinceRst < 3'd4) cycSinceRst <= cycSinceRst + 1'b1;
  end

  // R2
  bclk_level_chk: assert property (@(posedge clkMaster) disable iff (!rstN)
    (!$stable(bitClk) && cycSinceRst >= 3'd4) |->
      ($past(bitClk, 1) == $past(bitClk, 2) && $past(bitClk, 2) == $past(bitClk, 3) &&
       $past(bitClk, 3) == $past(bitClk, 4)));

  // R3
  ws_edge_chk: assert property (@(posedge clkMaster) disable iff (!rstN)
    !$stable(wordSel) |-> $fell(bitClk));

  // R4
  sdata_edge_chk: assert property (@(posedge clkMaster) disable iff (!rstN)
    !$stable(serData) |-> $fell(bitClk));

  // R7
  idx_step_chk: assert property (@(posedge clkMaster) disable iff (!rstN)
    !$stable(sampleIdx) |-> ($fell(wordSel) &&
      (sampleIdx == $past(sampleIdx) + 1'b1 || sampleIdx == '0)));

  // R8
  idx_wrap_chk: assert property (@(posedge clkMaster) disable iff (!rstN)
    (!$stable(sampleIdx) && sampleIdx == '0) |-> $past(sampleIdx) == IDX_W'(TABLE_LEN - 1));

  // R9
  always @(negedge clkMaster) begin
    if (rstN === 1'b0) begin
      rst_state_chk: assert (!bitClk && !wordSel && !serData && sampleIdx == '0);
    end
  end

endmodule

bind toneSerialGen toneSerialGenChk #(
  .IDX_W    (IdxW),
  .TABLE_LEN(TABLE_LEN)
) uChk (
  .clkMaster(clkMaster),
  .rstN     (rstN),
  .bitClk   (bitClk),
  .wordSel  (wordSel),
  .serData  (serData),
  .sampleIdx(sampleIdx)
);

// File: tb/sim_toneSerialGen.sv
module sim_toneSerialGen;

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  logic mclkOut, bitClk, wordSel, serData;

  toneSerialGen u0 (
    .clkMaster(clk),
    .rstN     (rstN),
    .mclkOut  (mclkOut),
    .bitClk   (bitClk),
    .wordSel  (wordSel),
    .serData  (serData)
  );

  always #2 clk = ~clk;

  int          tests = 0;
  int          fails = 0;
  int          k = 0;
  bit          done = 1'b0;
  logic        prevSer = 1'b0;
  logic [15:0] shiftWord = '0;
  int          leftVal = 0;
  bit          haveLeft = 1'b0;

  function automatic int expSample(int n);
    real v;
    v = 16383.0 * $sin(6.283185307179586 * 10.0 * real'(n) / 441.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return $rtoi(v - 0.5);
  endfunction

  task automatic check(string req, string what, int act, int exp, int tol);
    tests++;
    if (act - exp > tol || exp - act > tol) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (k=%0d)", req, what, act, exp, k);
    end
  endtask

  task automatic resetCheck();
    check("R9", "bitClk in reset", int'(bitClk), 0, 0);
    check("R9", "wordSel in reset", int'(wordSel), 0, 0);
    check("R9", "serData in reset", int'(serData), 0, 0);
  endtask

  task automatic step();
    int    frame, idx, pos, ph, val, expv;
    string tag;
    @(posedge clk);
    k++;
    #1;
    check("R1", "mclkOut high phase", int'(mclkOut), 1, 0);
    @(negedge clk);
    frame = k >> 8;
    idx   = frame % 441;
    pos   = (k >> 3) & 15;
    ph    = k & 7;
    check("R1", "mclkOut low phase", int'(mclkOut), 0, 0);
    check("R2", "bitClk level", int'(bitClk), (k >> 2) & 1, 0);
    check("R3", "wordSel level", int'(wordSel), (k >> 7) & 1, 0);
    if (ph != 0) check("R4", "serData steady within bit", int'(serData), int'(prevSer), 0);
    prevSer = serData;
    if (ph == 4) shiftWord = {shiftWord[14:0], serData};
    if (ph == 7 && pos == 15) begin
      val  = int'($signed(shiftWord));
      expv = expSample(idx);
      if (frame == 0)    tag = "R9";
      else if (idx == 0) tag = "R8";
      else               tag = "R7";
      check(tag, "slot word", val, expv, 1);
      check("R5", "MSB first sign bit", int'(shiftWord[15]), (expv < 0) ? 1 : 0, 0);
      if (((k >> 7) & 1) == 0) begin
        leftVal  = val;
        haveLeft = 1'b1;
      end else if (haveLeft) begin
        check("R6", "right equals left", val, leftVal, 0);
      end
    end
  endtask

  task automatic releaseReset();
    rstN     = 1'b1;
    k        = 0;
    prevSer  = 1'b0;
    haveLeft = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) begin
      @(negedge clk);
      resetCheck();
    end
    releaseReset();
    // R8: run past the 441st frame so the stored end marker wraps the index.
    repeat (113300) step();
    // Random reset points, including mid-word, then clean restart from entry 0 (R9).
    for (int r = 0; r < 3; r++) begin
      int runLen;
      int holdLen;
      runLen  = $urandom_range(3000, 300);
      holdLen = $urandom_range(4, 1);
      repeat (runLen) step();
      #1 rstN = 1'b0;
      #1 resetCheck();
      repeat (holdLen) begin
        @(negedge clk);
        resetCheck();
      end
      releaseReset();
    end
    repeat (2000) step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule